// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block sits between a set of asynchronous external interrupt pins and a main interrupt controller that only accepts active-high level requests. Every input line is brought into the clock domain through a two-flop synchronizer. It is then turned into a level-high request according to its own sense setting: active-high level, active-low level, rising edge or falling edge.

Edge-sensed lines keep a latched request until software acknowledges it. The latch keeps capturing while the line is masked, so a line that is unmasked later asserts at once unless its request was acknowledged first. Software can also raise a latched request itself. Each line has a mask bit, and only unmasked requests reach the outputs, one output per line.

A 32-bit APB-style register port exposes the registers. Each register word holds one bit per line, with line n at bit n.

| Offset | Register | Access |
| --- | --- | --- |
| 0x00 | block (mask) | read/write |
| 0x04 | route (source select) | read/write |
| 0x08 | pending (masked status) | read-only |
| 0x0C | raw status | read-only |
| 0x10 | acknowledge | write-one-to-clear, reads 0 |
| 0x14 | polarity | read/write |
| 0x18 | edge mode | read/write |
| 0x1C | software set | write-one-to-set, reads 0 |

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the block register (offset 0x00) reads 0xFFFFFFFF. The route (0x04), polarity (0x14) and edge-mode (0x18) registers read 0. All latched requests are clear and `irq_out` is 0.
- R2: The block, route, polarity and edge-mode registers read back the last value written. The acknowledge (0x10) and software-set (0x1C) offsets read as 0.
- R3: A line whose edge-mode bit is 0 is level-sensed. Its raw status bit (register 0x0C) is 1 exactly when the synchronized input equals its polarity bit: polarity 1 means active high, polarity 0 means active low.
- R4: A line whose edge-mode bit is 1 sets its latched request on a transition of the input. Polarity 1 selects a 0-to-1 transition and polarity 0 selects a 1-to-0 transition. The opposite transition does not set the request. The request stays set until it is acknowledged.
- R5: Writing the acknowledge register clears the latched request of every line written as 1 and leaves lines written as 0 unchanged. Writing 0xFFFFFFFF clears all lines in one access.
- R6: In level mode an acknowledge write has no lasting effect while the input is still active: the raw status stays 1.
- R7: `irq_out` and the pending register (0x08) equal raw status AND NOT block. A block bit of 1 forces that output low. Edge requests latch while blocked and appear at once when the block bit is cleared.
- R8: Writing 1 to a bit of the software-set register sets that line's latched request as if an edge had occurred. Bits written as 0 have no effect.
- R9: An input change reaches a level-mode output after two clock edges. It reaches an edge-mode output after three clock edges.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address, bits [4:2] pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a selected read |
| irq_in | input | NLINES | Asynchronous external interrupt lines |
| irq_out | output | NLINES | Active-high level requests to the main controller |

## Verification
A corrupted edge latch shows at the outputs in one of two ways. Either a request is missing three cycles after the qualifying transition, or a request survives an acknowledge write, which is visible on the cycle after the write commits. A wrong block or polarity register shows on the very next read, or on `irq_out` two cycles after the next input change. Because the raw status register separates the latched state from the blocked output, a fault can be placed either in capture or in masking.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NLINES = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NLINES-1:0] irq_in,
  output logic [NLINES-1:0] irq_out
);

  localparam logic [2:0] A_BLOCK = 3'd0;
  localparam logic [2:0] A_ROUTE = 3'd1;
  localparam logic [2:0] A_PEND  = 3'd2;
  localparam logic [2:0] A_RAW   = 3'd3;
  localparam logic [2:0] A_ACK   = 3'd4;
  localparam logic [2:0] A_POL   = 3'd5;
  localparam logic [2:0] A_MODE  = 3'd6;
  localparam logic [2:0] A_SWSET = 3'd7;

  logic [NLINES-1:0] mask_q, route_q, pol_q, mode_q, lat_q;
  logic [NLINES-1:0] s1_q, s2_q, s3_q;
  logic [NLINES-1:0] active, prev_active, edge_evt, ack, swset, raw;
  logic [2:0]        sel;
  logic              wr;

  assign sel = paddr[4:2];
  assign wr  = psel & penable & pwrite;

  assign ack   = (wr && sel == A_ACK)   ? pwdata[NLINES-1:0] : '0;
  assign swset = (wr && sel == A_SWSET) ? pwdata[NLINES-1:0] : '0;

  assign active      = ~(s2_q ^ pol_q);
  assign prev_active = ~(s3_q ^ pol_q);
  assign edge_evt    = active & ~prev_active & mode_q;

  assign raw     = lat_q | (active & ~mode_q);
  assign irq_out = raw & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= irq_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      route_q <= '0;
      pol_q   <= '0;
      mode_q  <= '0;
    end else if (wr) begin
      case (sel)
        A_BLOCK: mask_q  <= pwdata[NLINES-1:0];
        A_ROUTE: route_q <= pwdata[NLINES-1:0];
        A_POL:   pol_q   <= pwdata[NLINES-1:0];
        A_MODE:  mode_q  <= pwdata[NLINES-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~ack) | edge_evt | swset;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        A_BLOCK: prdata[NLINES-1:0] = mask_q;
        A_ROUTE: prdata[NLINES-1:0] = route_q;
        A_PEND:  prdata[NLINES-1:0] = irq_out;
        A_RAW:   prdata[NLINES-1:0] = raw;
        A_POL:   prdata[NLINES-1:0] = pol_q;
        A_MODE:  prdata[NLINES-1:0] = mode_q;
        default: prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NLINES = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [NLINES-1:0] irq_in,
  input logic [NLINES-1:0] irq_out,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] mode_q,
  input logic [NLINES-1:0] pol_q
);

  logic wr;
  assign wr = psel & penable & pwrite;

  // R7
  block_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[4:2] == 3'd0) |=> ((irq_out & $past(pwdata[NLINES-1:0])) == '0));

  // R8
  swset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[4:2] == 3'd7) |=>
      ((irq_out & $past(pwdata[NLINES-1:0])) == ($past(pwdata[NLINES-1:0]) & ~mask_q)));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[4:2] == 3'd4 && $stable(irq_in) && $past($stable(irq_in))
        && $past($stable(irq_in), 2) && $past($stable(irq_in), 3))
      |=> ((irq_out & mode_q & $past(pwdata[NLINES-1:0])) == '0));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && $past(!wr)) |->
      (((irq_out & mode_q) & $past(irq_out & mode_q)) == $past(irq_out & mode_q)));

  // R2
  pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[4:2] == 3'd5) |=> (pol_q == $past(pwdata[NLINES-1:0])));

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq_in(irq_in), .irq_out(irq_out),
  .mask_q(mask_q), .mode_q(mode_q), .pol_q(pol_q)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] irq_in = 32'hFFFF_FFFF;
  logic [31:0] irq_out;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  localparam logic [4:0] BLOCK = 5'h00, ROUTE = 5'h04, PEND = 5'h08, RAW = 5'h0C;
  localparam logic [4:0] ACK = 5'h10, POL = 5'h14, MODE = 5'h18, SWSET = 5'h1C;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic chk_rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h1234_5678;

    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    check("R1 irq_out", irq_out, 32'h0);
    chk_rd("R1 block", BLOCK, 32'hFFFF_FFFF);
    chk_rd("R1 route", ROUTE, 32'h0);
    chk_rd("R1 pol", POL, 32'h0);
    chk_rd("R1 mode", MODE, 32'h0);
    chk_rd("R1 raw", RAW, 32'h0);

    // R2 readback
    wr(BLOCK, 32'h1234_5678); chk_rd("R2 block", BLOCK, 32'h1234_5678);
    wr(ROUTE, 32'hCAFE_F00D); chk_rd("R2 route", ROUTE, 32'hCAFE_F00D);
    wr(POL, 32'h0F0F_F0F0);   chk_rd("R2 pol", POL, 32'h0F0F_F0F0);
    wr(MODE, 32'h8000_0001);  chk_rd("R2 mode", MODE, 32'h8000_0001);
    chk_rd("R2 ack reads 0", ACK, 32'h0);
    chk_rd("R2 swset reads 0", SWSET, 32'h0);

    // R3 level sweep
    p = 32'h0000_FFFF;
    wr(MODE, 32'h0); wr(POL, p); wr(BLOCK, 32'h0); wr(ACK, 32'hFFFF_FFFF);
    foreach (pats[i]) begin
      drive(pats[i]);
      settle();
      chk_rd("R3 raw", RAW, ~(pats[i] ^ p));
      chk_rd("R7 pend", PEND, ~(pats[i] ^ p));
      check("R3 irq_out", irq_out, ~(pats[i] ^ p));
    end
    // R9 level latency
    drive(32'h0000_0000);
    settle();
    drive(32'h0000_00FF);
    @(negedge clk); check("R9 level 1 edge", irq_out, 32'hFFFF_0000);
    @(negedge clk); check("R9 level 2 edges", irq_out, 32'hFFFF_00FF);

    // R4 edge sensing
    p = 32'h0F0F_0F0F;
    wr(POL, p); wr(MODE, 32'hFFFF_FFFF);
    drive(32'h0); settle();
    wr(ACK, 32'hFFFF_FFFF);
    chk_rd("R4 cleared", RAW, 32'h0);
    drive(32'hFFFF_FFFF);
    @(negedge clk); @(negedge clk);
    check("R9 edge 2 edges", irq_out, 32'h0);
    @(negedge clk);
    check("R9 edge 3 edges", irq_out, p);
    settle();
    chk_rd("R4 rising only", RAW, p);
    drive(32'h0); settle();
    chk_rd("R4 falling adds", RAW, 32'hFFFF_FFFF);
    wr(ACK, 32'h0000_FFFF);
    chk_rd("R5 partial ack", RAW, 32'hFFFF_0000);
    wr(ACK, 32'hFFFF_FFFF);
    chk_rd("R5 full ack", RAW, 32'h0);
    drive(32'h3C3C_3C3C); settle();
    chk_rd("R4 pattern rise", RAW, 32'h3C3C_3C3C & p);

    // R7 latch while blocked
    wr(BLOCK, 32'hFFFF_FFFF);
    drive(32'h0); settle();
    chk_rd("R7 raw while blocked", RAW, 32'h3C3C_3C3C);
    check("R7 blocked out", irq_out, 32'h0);
    chk_rd("R7 blocked pend", PEND, 32'h0);
    wr(ACK, 32'h0000_FFFF);
    wr(BLOCK, 32'h0);
    check("R7 unblock asserts", irq_out, 32'h3C3C_0000);

    // R8 software set
    wr(ACK, 32'hFFFF_FFFF);
    wr(SWSET, 32'h8000_0001);
    check("R8 swset out", irq_out, 32'h8000_0001);
    wr(SWSET, 32'h0);
    chk_rd("R8 zero bits no effect", RAW, 32'h8000_0001);
    wr(ACK, 32'h8000_0000);
    chk_rd("R5 ack one line", RAW, 32'h0000_0001);

    // R6 level ack has no lasting effect
    wr(MODE, 32'h0); wr(POL, 32'hFFFF_FFFF);
    drive(32'h00FF_00FF); settle();
    wr(ACK, 32'hFFFF_FFFF);
    settle();
    chk_rd("R6 level stays", RAW, 32'h00FF_00FF);
    check("R6 level out", irq_out, 32'h00FF_00FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule